// File: doc/BRIEF.md
# Wrapping Hardware Stack Pointer

This unit keeps the 16-bit stack pointer of a small 8-bit processor. The stack takes up a fixed, power-of-two sized window of the address space. Only the low bits of the pointer, enough to index one window, hold state and count. The upper bits are constants taken from the window base, so the pointer can never leave the window. The core issues one-byte push and pop commands and a command that puts the pointer back to its initial value. The unit returns the pointer and the address for the stack memory access of the current cycle.

The stack grows downward. A push writes the byte at the current pointer address and then decrements the pointer. A pop first increments the pointer and then reads at the new address. A subroutine call stacks two bytes and an interrupt entry stacks five. The core issues these as runs of single-byte pushes, and the matching pops return the pointer to its starting value.

The counter has no guard at either end. Pushing past the bottom of the window wraps the pointer to the top, and the oldest data is overwritten with no indication. Popping past the top wraps the pointer to the bottom in the same way. The defaults are a 128-byte window based at 0x0100, which gives a pointer range of 0x0100 to 0x017F with 7 live bits.

Top module: `stack_ptr_unit`

## Requirements
- R1: Bits 15 down to log2(DEPTH) of `sp_o` always equal the matching bits of BASE. With the defaults, `sp_o` stays within 0x0100..0x017F.
- R2: While `rst` is high at a clock edge, the pointer loads the top of the window (0x017F by default). It reads that value in the first cycle after reset.
- R3: `reload_i` loads the top of the window at the next edge. It has priority over `push_i` and `pop_i`, and with it high `acc_wr_o` is 0.
- R4: A push (`push_i` high, `reload_i` low) decrements the pointer by one at the next edge.
- R5: A pop (`pop_i` high, `push_i` and `reload_i` low) increments the pointer by one at the next edge.
- R6: A push at the bottom of the window (0x0100) wraps the pointer to the top (0x017F). No flag or other output shows the wrap.
- R7: A pop at the top of the window (0x017F) wraps the pointer to the bottom (0x0100). No flag is raised.
- R8: In a push cycle, `acc_addr_o` equals the current `sp_o` and `acc_wr_o` is 1, in the same cycle.
- R9: In a pop cycle, `acc_addr_o` equals `sp_o`+1, wrapped within the window, and `acc_wr_o` is 0. In a cycle with no command, `acc_addr_o` equals `sp_o` and `acc_wr_o` is 0.
- R10: When `push_i` and `pop_i` are both high and `reload_i` is low, the push is performed and the pop is ignored.
- R11: With no command asserted, the pointer holds its value.
- R12: Two pushes (a call frame) nested with five pushes (an interrupt frame), followed by seven pops, return the pointer to its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push one byte this cycle |
| pop_i | input | 1 | Pop one byte this cycle |
| reload_i | input | 1 | Return the pointer to the top of the window |
| sp_o | output | 16 | Full stack pointer, forced high bits included |
| acc_addr_o | output | 16 | Stack memory address for this cycle's access |
| acc_wr_o | output | 1 | High when this cycle's access is a write (push) |

## Verification
The hardest case to reach from the ports is the bottom-edge wrap. It only happens after the pointer has been walked through the whole window with no reload or reset on the way. The bench reloads and then issues exactly DEPTH-1 pushes to land on the bottom address, and one more push to cross it. It then reloads and pops once to cross the top edge. A long pseudo-random run of mixed commands drives the pointer around the window many times in both directions. A reference model tracks the pointer, so wraps taken mid-sequence and simultaneous commands are checked as well.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int unsigned SP_W = 16;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_PUSH   = 2'd1,
        OP_POP    = 2'd2,
        OP_RELOAD = 2'd3
    } stk_op_e;

    typedef struct packed {
        logic [SP_W-1:0] addr;
        logic            wr;
    } stk_access_t;

    function automatic int unsigned live_bits(input int unsigned depth);
        return $clog2(depth);
    endfunction

endpackage

// File: rtl/stk_op_select.sv
module stk_op_select
    import stk_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    input  logic    reload_i,
    output stk_op_e op_o
);
    always_comb begin
        if (reload_i)     op_o = OP_RELOAD;
        else if (push_i)  op_o = OP_PUSH;
        else if (pop_i)   op_o = OP_POP;
        else              op_o = OP_HOLD;
    end
endmodule

// File: rtl/stk_live_counter.sv
module stk_live_counter
    import stk_pkg::*;
#(
    parameter int unsigned LW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_op_e       op_i,
    output logic [LW-1:0] live_q,
    output logic [LW-1:0] live_inc
);
    localparam logic [LW-1:0] TOP = '1;

    assign live_inc = live_q + LW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= TOP;
        end else begin
            case (op_i)
                OP_RELOAD: live_q <= TOP;
                OP_PUSH:   live_q <= live_q - LW'(1);
                OP_POP:    live_q <= live_inc;
                default:   live_q <= live_q;
            endcase
        end
    end
endmodule

// File: rtl/stk_addr_compose.sv
module stk_addr_compose
    import stk_pkg::*;
#(
    parameter int unsigned     LW   = 7,
    parameter logic [SP_W-1:0] BASE = 16'h0100
) (
    input  stk_op_e         op_i,
    input  logic [LW-1:0]   live_q,
    input  logic [LW-1:0]   live_inc,
    output logic [SP_W-1:0] sp_o,
    output stk_access_t     acc_o
);
    localparam int unsigned     HI_W    = SP_W - LW;
    localparam logic [SP_W-1:0] HI_BITS = BASE >> LW;

    logic [SP_W-1:0] next_up;

    generate
        if (HI_W > 0) begin : g_forced
            assign sp_o    = {HI_BITS[HI_W-1:0], live_q};
            assign next_up = {HI_BITS[HI_W-1:0], live_inc};
        end else begin : g_full
            assign sp_o    = SP_W'(live_q);
            assign next_up = SP_W'(live_inc);
        end
    endgenerate

    always_comb begin
        acc_o.wr   = (op_i == OP_PUSH);
        acc_o.addr = (op_i == OP_POP) ? next_up : sp_o;
    end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import stk_pkg::*;
#(
    parameter int unsigned     DEPTH = 128,
    parameter logic [SP_W-1:0] BASE  = 16'h0100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic            reload_i,
    output logic [SP_W-1:0] sp_o,
    output logic [SP_W-1:0] acc_addr_o,
    output logic            acc_wr_o
);
    localparam int unsigned LW = live_bits(DEPTH);

    stk_op_e       op;
    logic [LW-1:0] live_q;
    logic [LW-1:0] live_inc;
    stk_access_t   acc;

    stk_op_select u_sel (
        .push_i   (push_i),
        .pop_i    (pop_i),
        .reload_i (reload_i),
        .op_o     (op)
    );

    stk_live_counter #(.LW(LW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op),
        .live_q   (live_q),
        .live_inc (live_inc)
    );

    stk_addr_compose #(.LW(LW), .BASE(BASE)) u_cmp (
        .op_i     (op),
        .live_q   (live_q),
        .live_inc (live_inc),
        .sp_o     (sp_o),
        .acc_o    (acc)
    );

    assign acc_addr_o = acc.addr;
    assign acc_wr_o   = acc.wr;
endmodule

// File: rtl/stk_ptr_checker.sv
module stk_ptr_checker
    import stk_pkg::*;
#(
    parameter int unsigned     DEPTH = 128,
    parameter logic [SP_W-1:0] BASE  = 16'h0100
) (
    input logic            clk,
    input logic            rst,
    input logic            push_i,
    input logic            pop_i,
    input logic            reload_i,
    input logic [SP_W-1:0] sp_o,
    input logic [SP_W-1:0] acc_addr_o,
    input logic            acc_wr_o
);
    localparam int unsigned     LW  = live_bits(DEPTH);
    localparam logic [LW-1:0]   TOP = '1;

    a_r1_forced_high: assert property (@(posedge clk) disable iff (rst)
        (sp_o >> LW) == (BASE >> LW));

    a_r2_reset_top: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> sp_o[LW-1:0] == TOP);

    a_r3_reload_top: assert property (@(posedge clk) disable iff (rst)
        reload_i |=> sp_o[LW-1:0] == TOP);

    a_r3_reload_no_write: assert property (@(posedge clk) disable iff (rst)
        reload_i |-> !acc_wr_o);

    a_r4_push_dec: assert property (@(posedge clk) disable iff (rst)
        (push_i && !reload_i) |=> sp_o[LW-1:0] == LW'($past(sp_o[LW-1:0]) - LW'(1)));

    a_r5_pop_inc: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && !reload_i) |=> sp_o[LW-1:0] == LW'($past(sp_o[LW-1:0]) + LW'(1)));

    a_r8_push_addr: assert property (@(posedge clk) disable iff (rst)
        (push_i && !reload_i) |-> (acc_wr_o && acc_addr_o == sp_o));

    a_r9_pop_addr: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && !reload_i) |->
            (!acc_wr_o && acc_addr_o[LW-1:0] == LW'(sp_o[LW-1:0] + LW'(1))
             && (acc_addr_o >> LW) == (BASE >> LW)));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!push_i && !pop_i && !reload_i) |=> $stable(sp_o));

endmodule

bind stack_ptr_unit stk_ptr_checker #(.DEPTH(DEPTH), .BASE(BASE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .reload_i   (reload_i),
    .sp_o       (sp_o),
    .acc_addr_o (acc_addr_o),
    .acc_wr_o   (acc_wr_o)
);

// File: tb/stack_ptr_unit_bench.sv
module stack_ptr_unit_bench;
    localparam int unsigned DEPTH = 128;
    localparam logic [15:0] BASE  = 16'h0100;
    localparam int          MASK  = DEPTH - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic        reload_i = 1'b0;
    logic [15:0] sp_o;
    logic [15:0] acc_addr_o;
    logic        acc_wr_o;

    int checks = 0;
    int fails  = 0;
    int exp_live = MASK;

    always #5 clk = ~clk;

    stack_ptr_unit #(.DEPTH(DEPTH), .BASE(BASE)) u_stack_ptr_unit (
        .clk        (clk),
        .rst        (rst),
        .push_i     (push_i),
        .pop_i      (pop_i),
        .reload_i   (reload_i),
        .sp_o       (sp_o),
        .acc_addr_o (acc_addr_o),
        .acc_wr_o   (acc_wr_o)
    );

    function automatic logic [15:0] exp_sp(input int live);
        return BASE | 16'(live & MASK);
    endfunction

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one command cycle: checks the access outputs before the edge and the pointer after it
    task automatic step(input logic p, input logic q, input logic r, input string req);
        logic [15:0] e_addr;
        logic        e_wr;
        @(negedge clk);
        push_i = p; pop_i = q; reload_i = r;
        #1;
        e_wr   = p && !r;
        e_addr = (!r && !p && q) ? exp_sp(exp_live + 1) : exp_sp(exp_live);
        check16({req, " acc_addr"}, acc_addr_o, e_addr);
        check16({req, " acc_wr"}, {15'd0, acc_wr_o}, {15'd0, e_wr});
        @(posedge clk);
        #1;
        if (r)      exp_live = MASK;
        else if (p) exp_live = (exp_live - 1) & MASK;
        else if (q) exp_live = (exp_live + 1) & MASK;
        check16({req, " sp"}, sp_o, exp_sp(exp_live));
        push_i = 0; pop_i = 0; reload_i = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_live = MASK;
        check16("R2 reset top", sp_o, 16'h017F);
        check16("R1 forced high", sp_o & 16'hFF80, 16'h0100);
    endtask

    task automatic t_push_pop();
        step(1, 0, 0, "R4 R8 push");
        check16("R4 push value", sp_o, 16'h017E);
        step(1, 0, 0, "R4 push2");
        step(0, 1, 0, "R5 R9 pop");
        check16("R5 pop value", sp_o, 16'h017E);
        step(0, 0, 0, "R11 R9 idle");
        step(0, 0, 0, "R11 idle2");
    endtask

    task automatic t_wrap_bottom();
        step(0, 0, 1, "R3 reload");
        for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0, "R4 walk down");
        check16("R6 at bottom", sp_o, 16'h0100);
        step(1, 0, 0, "R6 wrap down");
        check16("R6 wrapped top", sp_o, 16'h017F);
    endtask

    task automatic t_wrap_top();
        step(0, 0, 1, "R3 reload");
        step(0, 1, 0, "R7 R9 wrap up");
        check16("R7 wrapped bottom", sp_o, 16'h0100);
        step(1, 0, 0, "R6 push at bottom");
        check16("R6 back to top", sp_o, 16'h017F);
    endtask

    task automatic t_priority();
        step(1, 0, 0, "R4 pre");
        step(1, 0, 0, "R4 pre2");
        step(1, 1, 1, "R3 reload beats all");
        check16("R3 reload value", sp_o, 16'h017F);
        step(1, 1, 0, "R10 push beats pop");
        check16("R10 value", sp_o, 16'h017E);
        step(0, 1, 1, "R3 reload beats pop");
    endtask

    task automatic t_frames();
        int start;
        step(1, 0, 0, "R12 pre");
        start = exp_live;
        for (int i = 0; i < 2; i++) step(1, 0, 0, "R12 call push");
        for (int i = 0; i < 5; i++) step(1, 0, 0, "R12 irq push");
        check16("R12 depth 7", sp_o, exp_sp(start - 7));
        for (int i = 0; i < 7; i++) step(0, 1, 0, "R12 unstack");
        check16("R12 restored", sp_o, exp_sp(start));
    endtask

    task automatic t_random();
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] & ~lfsr[1], lfsr[1] | (lfsr[0] & lfsr[2]),
                 (lfsr[7:3] == 5'd0), "R1 R4 R5 random");
            checks++;
            if ((sp_o & 16'hFF80) != 16'h0100) begin
                fails++;
                $display("FAIL R1 window: actual %h expected 0100..017F", sp_o);
            end
        end
    endtask

    task automatic t_mid_reset();
        step(1, 0, 0, "R4 pre");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check16("R2 mid-run reset", sp_o, 16'h017F);
        @(negedge clk);
        rst = 1'b0;
        exp_live = MASK;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_push_pop();
        t_wrap_bottom();
        t_wrap_top();
        t_priority();
        t_frames();
        t_random();
        t_mid_reset();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule